// File: doc/BRIEF.md
# DMA Peripheral Request Handshake Sequencer

This block is the control logic of one DMA channel that faces a peripheral. It watches the peripheral's burst request line and single request line, plus a software request strobe. For each request it accepts, it decides how many beats the bus transfer engine must move. It issues a one-cycle start pulse with that beat count and then counts the beat-complete pulses that come back. After the last beat it raises a clear acknowledge and holds it until the peripheral drops the request it was serving. One clear line serves both request types.

The channel is armed by a pulse on `chan_en`, which loads the programmed total. `flow_own` selects whether the channel sets the transfer length (high) or the peripheral does (low). In channel-owned mode only the burst line matters, and the last burst is shortened to whatever remains. In peripheral-owned mode the burst line is watched while at least one full burst remains. Once less than a burst remains, the channel watches the single line and moves one beat per request.

The state machine has five states:
- IDLE: reached after reset.
- WAIT_REQ: waiting for a request on the selected line. An enable pulse in IDLE or DONE leads here.
- XFER: entered when a request is accepted. The channel counts beats here.
- CLR_WAIT: entered after the beat-complete pulse for the last beat of the request. The clear line is high in this state.
- DONE: reached from CLR_WAIT once the serviced line is seen low and nothing remains. It is also entered straight from an enable pulse in channel-owned mode with a zero total.

From CLR_WAIT, the channel returns to WAIT_REQ once the serviced line is seen low and data still remains. A new enable pulse in DONE restarts the channel.

Top module: `dma_req_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the channel goes to IDLE. After that edge, `xfer_start`, `req_clear`, `chan_busy`, `chan_done` and `src_conflict` all read 0.
- R2: With `flow_own`=1, only `per_burst_req` starts a transfer. `per_single_req` is ignored. Each accepted request moves min(`burst_beats`, remaining) beats. A total of 17 with a burst of 4 gives 4,4,4,4,1.
- R3: With `flow_own`=0, `per_burst_req` is watched and moves `burst_beats` beats while remaining ≥ `burst_beats`. Below that, only `per_single_req` is watched, and each accepted request moves exactly 1 beat.
- R4: `req_clear` first reads high in the cycle right after the `beat_done` pulse that completes the last beat of the request. It is low during the earlier beats.
- R5: `req_clear` stays high while the serviced request line is sampled high. It drops one clock after that line is sampled low. A request held high while `req_clear` is high never causes a new `xfer_start`.
- R6: The same `req_clear` output acknowledges both burst-line and single-line requests.
- R7: `xfer_start` is a one-cycle pulse in the cycle after a request is accepted. `xfer_beats` carries the nonzero beat count at the same time.
- R8: A `chan_en` pulse in IDLE or DONE loads the remaining count from `total_beats`. The count drops by one on each `beat_done` pulse in XFER. After the clear handshake that leaves zero remaining, `chan_done`=1 and `chan_busy`=0. Before that, `chan_busy`=1.
- R9: A `soft_req` strobe in WAIT_REQ with no watched hardware request starts a transfer with the same beat count. Its clear lasts exactly one cycle.
- R10: If `soft_req` and the watched hardware request are high in the same WAIT_REQ cycle, the hardware request is served and `src_conflict` becomes 1. It stays 1 until reset.
- R11: With a zero total, `flow_own`=1 goes straight to DONE on enable. With `flow_own`=0, the next single request is served as a 1-beat last transfer and the channel ends after its clear handshake. A burst request is ignored in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Arm pulse; loads the total and starts the channel |
| flow_own | input | 1 | 1: channel sets the transfer length; 0: peripheral does |
| burst_beats | input | BL_W | Beats per burst (0 treated as 1) |
| total_beats | input | CNT_W | Programmed transfer length in beats |
| per_burst_req | input | 1 | Peripheral burst request line |
| per_single_req | input | 1 | Peripheral single request line |
| soft_req | input | 1 | Software request strobe |
| beat_done | input | 1 | Pulse from the engine when a beat's data phase ends |
| xfer_start | output | 1 | One-cycle pulse to start the engine |
| xfer_beats | output | CNT_W | Beat count for the started transfer |
| req_clear | output | 1 | Clear acknowledge back to the peripheral |
| chan_busy | output | 1 | Channel armed and not finished |
| chan_done | output | 1 | All programmed data moved |
| src_conflict | output | 1 | Sticky flag: software and hardware requests collided |

## Verification
The hardest situation to reach from the ports is a slow peripheral. It keeps its request high for several cycles after the clear rises, while the other request line is also high. At the same time, in peripheral-owned mode, the remaining count crosses below the burst size, so the watched line changes between two requests. The bench models the engine with random gaps between beat pulses and holds each request for a random number of cycles after the clear. Before each real request, it raises the unwatched line for a few cycles. Random totals and burst sizes drive the remaining count through that crossing. Directed runs cover the 17-by-4 split, zero totals in both modes, and a software/hardware collision.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_XFER,
        ST_CLR_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_BURST,
        SRC_SINGLE,
        SRC_SOFT
    } req_src_e;
endpackage

// File: rtl/dma_seq_remaining.sv
module dma_seq_remaining #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem,
    output logic             rem_zero
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (dec && rem != '0)
            rem <= rem - 1'b1;
    end

    assign rem_zero = (rem == '0);
endmodule

// File: rtl/dma_seq_select.sv
module dma_seq_select
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BL_W  = 4
) (
    input  logic             flow_own,
    input  logic [CNT_W-1:0] rem,
    input  logic [BL_W-1:0]  burst_beats,
    input  logic             per_burst_req,
    input  logic             per_single_req,
    input  logic             soft_req,
    output logic             hw_hit,
    output logic             soft_hit,
    output logic             collide,
    output req_src_e         watched,
    output logic [CNT_W-1:0] beats
);
    logic [CNT_W-1:0] burst_ext;
    logic             short_tail;

    always_comb begin
        burst_ext  = (burst_beats == '0) ? CNT_W'(1) : CNT_W'(burst_beats);
        short_tail = (rem < burst_ext);
        if (flow_own) begin
            watched = SRC_BURST;
            hw_hit  = per_burst_req;
            beats   = short_tail ? rem : burst_ext;
        end else if (short_tail) begin
            watched = SRC_SINGLE;
            hw_hit  = per_single_req;
            beats   = CNT_W'(1);
        end else begin
            watched = SRC_BURST;
            hw_hit  = per_burst_req;
            beats   = burst_ext;
        end
        soft_hit = soft_req && !hw_hit;
        collide  = soft_req && hw_hit;
    end
endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             flow_own,
    input  logic [BL_W-1:0]  burst_beats,
    input  logic [CNT_W-1:0] total_beats,
    input  logic             per_burst_req,
    input  logic             per_single_req,
    input  logic             soft_req,
    input  logic             beat_done,
    output logic             xfer_start,
    output logic [CNT_W-1:0] xfer_beats,
    output logic             req_clear,
    output logic             chan_busy,
    output logic             chan_done,
    output logic             src_conflict
);
    seq_state_e       state, state_nx;
    req_src_e         srv_src, watched;
    logic [CNT_W-1:0] rem, sel_beats, beats_left, beats_q;
    logic             rem_zero, hw_hit, soft_hit, collide;
    logic             start_q, conflict_q;
    logic             armable, accept, last_beat, line_low;

    assign armable   = (state == ST_IDLE) || (state == ST_DONE);
    assign accept    = (state == ST_WAIT_REQ) && (hw_hit || soft_hit);
    assign last_beat = (state == ST_XFER) && beat_done && (beats_left == CNT_W'(1));

    dma_seq_remaining #(.CNT_W(CNT_W)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (chan_en && armable),
        .load_val (total_beats),
        .dec      ((state == ST_XFER) && beat_done),
        .rem      (rem),
        .rem_zero (rem_zero)
    );

    dma_seq_select #(.CNT_W(CNT_W), .BL_W(BL_W)) u_sel (
        .flow_own       (flow_own),
        .rem            (rem),
        .burst_beats    (burst_beats),
        .per_burst_req  (per_burst_req),
        .per_single_req (per_single_req),
        .soft_req       (soft_req),
        .hw_hit         (hw_hit),
        .soft_hit       (soft_hit),
        .collide        (collide),
        .watched        (watched),
        .beats          (sel_beats)
    );

    // Level of the line being acknowledged; a software strobe counts as already low.
    always_comb begin
        unique case (srv_src)
            SRC_BURST:  line_low = !per_burst_req;
            SRC_SINGLE: line_low = !per_single_req;
            default:    line_low = 1'b1;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE:
                if (chan_en)
                    state_nx = (flow_own && total_beats == '0) ? ST_DONE : ST_WAIT_REQ;
            ST_WAIT_REQ:
                if (accept) state_nx = ST_XFER;
            ST_XFER:
                if (last_beat) state_nx = ST_CLR_WAIT;
            ST_CLR_WAIT:
                if (line_low) state_nx = rem_zero ? ST_DONE : ST_WAIT_REQ;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= 1'b0;
            beats_q    <= '0;
            beats_left <= '0;
            srv_src    <= SRC_NONE;
            conflict_q <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept) begin
                beats_q    <= sel_beats;
                beats_left <= sel_beats;
                srv_src    <= hw_hit ? watched : SRC_SOFT;
                if (collide) conflict_q <= 1'b1;
            end else if ((state == ST_XFER) && beat_done && beats_left != '0) begin
                beats_left <= beats_left - 1'b1;
            end
        end
    end

    always_comb begin
        xfer_start   = start_q;
        xfer_beats   = beats_q;
        req_clear    = (state == ST_CLR_WAIT);
        chan_busy    = (state == ST_WAIT_REQ) || (state == ST_XFER) || (state == ST_CLR_WAIT);
        chan_done    = (state == ST_DONE);
        src_conflict = conflict_q;
    end
endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             per_burst_req,
    input logic             per_single_req,
    input logic             beat_done,
    input logic             xfer_start,
    input logic [CNT_W-1:0] xfer_beats,
    input logic             req_clear,
    input logic             chan_busy,
    input logic             chan_done,
    input logic             src_conflict,
    input req_src_e         srv_src
);
    a_r4_clear_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_clear) |-> $past(beat_done));

    a_r5_clear_held_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clear && ((srv_src == SRC_BURST && per_burst_req) ||
                       (srv_src == SRC_SINGLE && per_single_req))) |=> req_clear);

    a_r5_no_restart_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_clear |=> !xfer_start);

    a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    a_r7_beats_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (xfer_beats != '0));

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> !chan_busy);

    a_r9_soft_clear_short: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clear && srv_src == SRC_SOFT) |=> !req_clear);

    a_r10_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        src_conflict |=> src_conflict);
endmodule

bind dma_req_sequencer dma_seq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .per_burst_req  (per_burst_req),
    .per_single_req (per_single_req),
    .beat_done      (beat_done),
    .xfer_start     (xfer_start),
    .xfer_beats     (xfer_beats),
    .req_clear      (req_clear),
    .chan_busy      (chan_busy),
    .chan_done      (chan_done),
    .src_conflict   (src_conflict),
    .srv_src        (srv_src)
);

// File: tb/sim_dma_req_sequencer.sv
module sim_dma_req_sequencer;
    localparam int CNT_W = 16;
    localparam int BL_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chan_en = 1'b0;
    logic             flow_own = 1'b0;
    logic [BL_W-1:0]  burst_beats = '0;
    logic [CNT_W-1:0] total_beats = '0;
    logic             per_burst_req = 1'b0;
    logic             per_single_req = 1'b0;
    logic             soft_req = 1'b0;
    logic             beat_done = 1'b0;
    logic             xfer_start;
    logic [CNT_W-1:0] xfer_beats;
    logic             req_clear;
    logic             chan_busy;
    logic             chan_done;
    logic             src_conflict;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_req_sequencer #(.CNT_W(CNT_W), .BL_W(BL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .flow_own(flow_own),
        .burst_beats(burst_beats), .total_beats(total_beats),
        .per_burst_req(per_burst_req), .per_single_req(per_single_req),
        .soft_req(soft_req), .beat_done(beat_done), .xfer_start(xfer_start),
        .xfer_beats(xfer_beats), .req_clear(req_clear), .chan_busy(chan_busy),
        .chan_done(chan_done), .src_conflict(src_conflict)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Reference: line 0 = burst, 1 = single; returns beats for one request.
    function automatic int ref_beats(input bit flow, input int rem, input int bs, output int line);
        if (flow) begin
            line = 0;
            return (rem < bs) ? rem : bs;
        end else if (rem < bs) begin
            line = 1;
            return 1;
        end else begin
            line = 0;
            return bs;
        end
    endfunction

    task automatic drive_line(input int line, input bit v);
        if (line == 0) per_burst_req = v;
        else           per_single_req = v;
    endtask

    task automatic do_req(input int line, input int exp_b, input bit use_sw,
                          input bit noise, input bit collide_sw);
        string tg;
        tg = (line == 0) ? "R2/R3 burst" : "R3 single";
        if (noise) begin
            drive_line(1 - line, 1'b1);
            for (int k = 0; k < 2; k++) begin
                step();
                chk(xfer_start == 1'b0, {tg, " unwatched line ignored"}, xfer_start, 0);
            end
            drive_line(1 - line, 1'b0);
        end
        if (use_sw) soft_req = 1'b1;
        else begin
            drive_line(line, 1'b1);
            if (collide_sw) soft_req = 1'b1;
        end
        step();
        soft_req = 1'b0;
        chk(xfer_start == 1'b1, "R7 start pulse", xfer_start, 1);
        chk(int'(xfer_beats) == exp_b, {tg, " beat count"}, int'(xfer_beats), exp_b);
        for (int b = 0; b < exp_b; b++) begin
            repeat ($urandom_range(0, 2)) begin
                step();
                chk(req_clear == 1'b0, "R4 clear low mid transfer", req_clear, 0);
            end
            beat_done = 1'b1;
            step();
            beat_done = 1'b0;
            if (b == 0) chk(xfer_start == 1'b0, "R7 start one cycle", xfer_start, 0);
            if (b < exp_b - 1)
                chk(req_clear == 1'b0, "R4 clear low before last beat", req_clear, 0);
        end
        chk(req_clear == 1'b1, "R4/R6 clear after last beat", req_clear, 1);
        if (!use_sw) begin
            repeat ($urandom_range(0, 3)) begin
                step();
                chk(req_clear == 1'b1, "R5 clear held while request high", req_clear, 1);
                chk(xfer_start == 1'b0, "R5 no restart during clear", xfer_start, 0);
            end
            drive_line(line, 1'b0);
            step();
            chk(req_clear == 1'b0, "R5 clear drops after request low", req_clear, 0);
        end else begin
            step();
            chk(req_clear == 1'b0, "R9 soft clear one cycle", req_clear, 0);
        end
    endtask

    task automatic run_channel(input bit flow, input int count, input int bs,
                               input bit rnd_extras, input bit force_collide);
        int rem;
        int line;
        int b;
        bit sw;
        bit col;
        flow_own    = flow;
        total_beats = CNT_W'(count);
        burst_beats = BL_W'(bs);
        chan_en = 1'b1;
        step();
        chan_en = 1'b0;
        if (flow && count == 0) begin
            chk(chan_done == 1'b1, "R11 zero total channel-owned done", chan_done, 1);
            chk(chan_busy == 1'b0, "R11 zero total not busy", chan_busy, 0);
            return;
        end
        chk(chan_busy == 1'b1, "R8 busy after enable", chan_busy, 1);
        rem = count;
        do begin
            b   = ref_beats(flow, rem, bs, line);
            sw  = rnd_extras && ($urandom_range(0, 4) == 0);
            col = force_collide;
            force_collide = 1'b0;
            do_req(line, b, sw && !col, rnd_extras && ($urandom_range(0, 1) == 1), col);
            rem = (rem > b) ? rem - b : 0;
            if (rem > 0) begin
                chk(chan_busy == 1'b1, "R8 busy while data remains", chan_busy, 1);
                chk(chan_done == 1'b0, "R8 not done while data remains", chan_done, 0);
            end
        end while (rem > 0);
        chk(chan_done == 1'b1, "R8 done after final handshake", chan_done, 1);
        chk(chan_busy == 1'b0, "R8 not busy when done", chan_busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R8: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) step();
        chk(xfer_start == 1'b0, "R1 reset start", xfer_start, 0);
        chk(req_clear == 1'b0, "R1 reset clear", req_clear, 0);
        chk(chan_busy == 1'b0, "R1 reset busy", chan_busy, 0);
        chk(chan_done == 1'b0, "R1 reset done", chan_done, 0);
        chk(src_conflict == 1'b0, "R1 reset conflict", src_conflict, 0);
        rst_n = 1'b1;
        step();

        // R2: 17 beats, burst 4, channel owns length -> 4,4,4,4,1
        run_channel(1'b1, 17, 4, 1'b0, 1'b0);
        // R3: peripheral owns length, crosses from burst to single requests
        run_channel(1'b0, 11, 4, 1'b0, 1'b0);
        // R11: zero totals in both modes
        run_channel(1'b1, 0, 4, 1'b0, 1'b0);
        per_burst_req = 1'b1;
        flow_own = 1'b0; total_beats = '0; burst_beats = 4;
        chan_en = 1'b1; step(); chan_en = 1'b0;
        repeat (2) begin
            step();
            chk(xfer_start == 1'b0, "R11 burst ignored at zero total", xfer_start, 0);
        end
        per_burst_req = 1'b0;
        do_req(1, 1, 1'b0, 1'b0, 1'b0);
        chk(chan_done == 1'b1, "R11 single last transfer ends channel", chan_done, 1);
        // R10: collision, hardware wins, flag sticky
        chk(src_conflict == 1'b0, "R10 no conflict yet", src_conflict, 0);
        run_channel(1'b0, 8, 4, 1'b0, 1'b1);
        chk(src_conflict == 1'b1, "R10 conflict flagged", src_conflict, 1);
        // R9: software-only request
        run_channel(1'b1, 3, 2, 1'b0, 1'b0);
        flow_own = 1'b1; total_beats = 2; burst_beats = 4;
        chan_en = 1'b1; step(); chan_en = 1'b0;
        do_req(0, 2, 1'b1, 1'b0, 1'b0);
        chk(chan_done == 1'b1, "R9 soft request completes channel", chan_done, 1);

        // Constrained random channels
        for (int i = 0; i < 30; i++) begin
            run_channel(1'($urandom_range(0, 1)), int'($urandom_range(0, 20)),
                        int'($urandom_range(1, 8)), 1'b1, 1'b0);
        end
        chk(src_conflict == 1'b1, "R10 conflict still set", src_conflict, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule